// File: doc/BRIEF.md
# Two-Wire Slave Register Port

This block lets an external two-wire bus master read and write a small bank of byte registers. It samples the open-drain clock and data lines with a faster system clock. It recognises start, repeated-start and stop conditions and answers only to one fixed 7-bit device address. The data line is never driven high. The block only pulls it low through an output enable, and the board's pull-up brings the line high again when the enable is released.

After the device address is acknowledged, the direction bit selects the transfer. In a write, the first byte becomes the register pointer and every later byte is stored at the pointer. In a read, the block sends the byte at the pointer. In both directions the pointer steps after every byte and wraps at the end of the bank. Wider values are kept with the high byte at the even address and the low byte at the next address, so a 16-bit word moves as two consecutive bytes.

Top module: `twi_regfile_slave`

## Requirements
- R1: After reset the data-line enable `sda_oe` is 0, every register byte reads 0x00 and the pointer is 0.
- R2: A falling data line while the clock is high is a start. A rising data line while the clock is high is a stop. A stop returns the block to idle from any point, even in the middle of a byte, and the bits of that unfinished byte are not stored.
- R3: The block acknowledges a byte by pulling the line low for the ninth clock pulse. It acknowledges the address byte only when the top seven bits equal 7'b0110110, which is 0x6C for a write and 0x6D for a read. For any other address it keeps `sda_oe` at 0 until the next start.
- R4: In a write (bit 0 of the address byte is 0), the first data byte loads the pointer from its low log2(NBYTES) bits. Each later byte is stored at the pointer. Every one of these bytes is acknowledged.
- R5: In a read (bit 0 is 1), the block drives the byte at the pointer most significant bit first. After a master acknowledge it continues with the next byte. After a not-acknowledge it releases the line and waits for a start.
- R6: The pointer advances by one after every byte that is stored or sent, and wraps from NBYTES-1 to 0.
- R7: A repeated start abandons the current byte without storing it, keeps the pointer, and starts a new address byte.
- R8: `sda_oe` changes only after a detected falling clock edge, and never while the clock is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8 times the bus bit rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Bus clock line as seen at the pin |
| sda_in | input | 1 | Bus data line as seen at the pin |
| sda_oe | output | 1 | 1 pulls the data line low; 0 releases it |

## Verification
The assertions assume that the clock line holds each level for many system clocks. They also assume that the master changes the data line only while the clock is low, except to form a start or a stop. The bench's master meets both assumptions. It holds each clock level for 20 system clocks and changes the data line a few cycles after the clock has fallen, once both synchronizers have settled. The bench combines the master's drive with `sda_oe` as a wired AND, so the block sees its own acknowledges and the stop conditions on the real line level.

// File: rtl/twi_regfile_slave.sv
module twi_regfile_slave #(
  parameter logic [6:0] DEV_ADDR = 7'b0110110,
  parameter int         NBYTES   = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic sda_oe
);
  localparam int PW = $clog2(NBYTES);

  typedef enum logic [2:0] {ST_IDLE, ST_ADDR, ST_AACK, ST_RX, ST_RACK, ST_TX, ST_MACK} st_t;

  st_t           state;
  logic [1:0]    scl_m, sda_m;
  logic          scl_q, sda_q;
  logic [3:0]    cnt;
  logic [7:0]    sh;
  logic          rw, first, macked;
  logic [PW-1:0] ptr;
  logic [7:0]    mem [NBYTES];

  logic scl_s, sda_s, scl_rise, scl_fall, start, stop, byte_end;
  assign scl_s    = scl_m[1];
  assign sda_s    = sda_m[1];
  assign scl_rise = scl_s & ~scl_q;
  assign scl_fall = ~scl_s & scl_q;
  assign start    = scl_s & scl_q & sda_q & ~sda_s;
  assign stop     = scl_s & scl_q & ~sda_q & sda_s;
  assign byte_end = scl_fall && cnt == 4'd8;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_m  <= 2'b11;
      sda_m  <= 2'b11;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
      state  <= ST_IDLE;
      cnt    <= '0;
      sh     <= '0;
      rw     <= 1'b0;
      first  <= 1'b0;
      macked <= 1'b0;
      ptr    <= '0;
      sda_oe <= 1'b0;
      for (int i = 0; i < NBYTES; i++) mem[i] <= '0;
    end else begin
      scl_m <= {scl_m[0], scl_in};
      sda_m <= {sda_m[0], sda_in};
      scl_q <= scl_s;
      sda_q <= sda_s;
      if (start) begin
        state  <= ST_ADDR;
        cnt    <= '0;
        first  <= 1'b1;
        sda_oe <= 1'b0;
      end else if (stop) begin
        state  <= ST_IDLE;
        sda_oe <= 1'b0;
      end else begin
        case (state)
          ST_ADDR: begin
            if (scl_rise) begin
              sh  <= {sh[6:0], sda_s};
              cnt <= cnt + 4'd1;
            end else if (byte_end) begin
              cnt <= '0;
              if (sh[7:1] == DEV_ADDR) begin
                rw     <= sh[0];
                sda_oe <= 1'b1;
                state  <= ST_AACK;
              end else begin
                state <= ST_IDLE;
              end
            end
          end
          ST_AACK: begin
            if (scl_fall) begin
              cnt <= '0;
              if (rw) begin
                sh     <= mem[ptr];
                sda_oe <= ~mem[ptr][7];
                state  <= ST_TX;
              end else begin
                sda_oe <= 1'b0;
                state  <= ST_RX;
              end
            end
          end
          ST_RX: begin
            if (scl_rise) begin
              sh  <= {sh[6:0], sda_s};
              cnt <= cnt + 4'd1;
            end else if (byte_end) begin
              cnt    <= '0;
              sda_oe <= 1'b1;
              state  <= ST_RACK;
              if (first) begin
                ptr   <= sh[PW-1:0];
                first <= 1'b0;
              end else begin
                mem[ptr] <= sh;
                ptr      <= ptr + 1'b1;
              end
            end
          end
          ST_RACK: begin
            if (scl_fall) begin
              sda_oe <= 1'b0;
              state  <= ST_RX;
            end
          end
          ST_TX: begin
            if (scl_rise) begin
              cnt <= cnt + 4'd1;
            end else if (byte_end) begin
              sda_oe <= 1'b0;
              ptr    <= ptr + 1'b1;
              state  <= ST_MACK;
            end else if (scl_fall) begin
              sh     <= {sh[6:0], 1'b0};
              sda_oe <= ~sh[6];
            end
          end
          ST_MACK: begin
            if (scl_rise) begin
              macked <= ~sda_s;
            end else if (scl_fall) begin
              cnt <= '0;
              if (macked) begin
                sh     <= mem[ptr];
                sda_oe <= ~mem[ptr][7];
                state  <= ST_TX;
              end else begin
                state <= ST_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  a_r8_oe_quiet_scl_high: assert property (@(posedge clk) disable iff (!rst_n)
    $past(scl_s) |-> $stable(sda_oe));

  a_r3_no_drive_unaddressed: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE || state == ST_ADDR) |-> !sda_oe);

  a_r2_stop_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> state == ST_IDLE && !sda_oe);

  a_r7_restart_addr: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> state == ST_ADDR && cnt == 4'd0);

  a_r4_ack_rx_byte: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RX && byte_end) |=> sda_oe && state == ST_RACK);

  a_r6_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RX && byte_end && !first) |=> ptr == PW'($past(ptr) + 1'b1));
endmodule

// File: tb/twi_regfile_slave_test.sv
module twi_regfile_slave_test;
  localparam int H = 20;
  localparam int NB = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic sda_drv = 1'b1;
  logic sda_oe;
  logic line;
  int checks = 0;
  int errors = 0;
  logic done = 1'b0;
  logic [7:0] ref_mem [NB];
  int ref_ptr = 0;

  assign line = sda_drv & ~sda_oe;

  always #5 clk = ~clk;

  twi_regfile_slave uut (
    .clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(line), .sda_oe(sda_oe)
  );

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // one bit: data set while SCL low, enable compared on every clock of the high phase
  task automatic xbit(input logic b, input logic exp_oe, input string req, output logic seen);
    logic bad;
    bad = 1'b0;
    wait_clk(4);
    sda_drv = b;
    wait_clk(H);
    scl = 1'b1;
    for (int i = 0; i < H; i++) begin
      @(negedge clk);
      if (i > 4 && sda_oe !== exp_oe) bad = 1'b1;
    end
    seen = line;
    chk(!bad, {req, " R8 oe level"}, sda_oe, exp_oe);
    scl = 1'b0;
  endtask

  task automatic bus_start();
    wait_clk(4);
    sda_drv = 1'b1;
    wait_clk(H);
    scl = 1'b1;
    wait_clk(H);
    sda_drv = 1'b0;
    wait_clk(H);
    scl = 1'b0;
  endtask

  task automatic bus_stop();
    wait_clk(4);
    sda_drv = 1'b0;
    wait_clk(H);
    scl = 1'b1;
    wait_clk(H);
    sda_drv = 1'b1;
    wait_clk(H);
  endtask

  task automatic wbyte(input logic [7:0] d, input logic exp_ack, input string req);
    logic s;
    for (int i = 7; i >= 0; i--) xbit(d[i], 1'b0, req, s);
    xbit(1'b1, exp_ack, req, s);
    chk(s == ~exp_ack, {req, " ack bit"}, s, ~exp_ack);
  endtask

  task automatic rbyte(input logic [7:0] exp, input logic mack, input string req);
    logic s;
    logic [7:0] got;
    for (int i = 7; i >= 0; i--) begin
      xbit(1'b1, ~exp[i], req, s);
      got[i] = s;
    end
    chk(got == exp, {req, " read data"}, got, exp);
    xbit(~mack, 1'b0, req, s);
  endtask

  task automatic wr_seq(input int p, input logic [7:0] d[$], input string req);
    bus_start();
    wbyte(8'h6C, 1'b1, "R3");
    wbyte(8'(p), 1'b1, req);
    ref_ptr = p % NB;
    foreach (d[i]) begin
      wbyte(d[i], 1'b1, req);
      ref_mem[ref_ptr] = d[i];
      ref_ptr = (ref_ptr + 1) % NB;
    end
  endtask

  task automatic rd_body(input int n, input string req);
    wbyte(8'h6D, 1'b1, "R3");
    for (int i = 0; i < n; i++) begin
      rbyte(ref_mem[ref_ptr], i != n - 1, req);
      ref_ptr = (ref_ptr + 1) % NB;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] q[$];
    logic s;
    for (int i = 0; i < NB; i++) ref_mem[i] = 8'h00;
    wait_clk(5);
    chk(sda_oe == 1'b0, "R1 reset enable", sda_oe, 0);
    rst_n = 1'b1;
    wait_clk(10);
    chk(sda_oe == 1'b0, "R1 idle enable", sda_oe, 0);

    // foreign address: no ack, bytes ignored
    bus_start();
    wbyte(8'h50, 1'b0, "R3 foreign addr");
    wbyte(8'h00, 1'b0, "R3 ignored");
    wbyte(8'h99, 1'b0, "R3 ignored");
    bus_stop();

    // word pair at even address plus one byte
    q = '{8'h12, 8'h34, 8'h56};
    wr_seq(2, q, "R4");
    bus_stop();

    // pointer set then repeated start into read; reset contents and ordering
    q = '{};
    wr_seq(0, q, "R4");
    bus_start();
    rd_body(6, "R5 R1");
    bus_stop();

    // read resumes at pointer left by previous read
    bus_start();
    rd_body(2, "R6 continue");
    bus_stop();

    // pointer load uses low bits only, then wrap
    q = '{8'hAA, 8'hBB};
    wr_seq(8'hFF, q, "R6 wrap write");
    bus_stop();
    q = '{};
    wr_seq(14, q, "R4");
    bus_start();
    rd_body(4, "R6 wrap read");
    bus_stop();

    // repeated start in the middle of a data byte
    q = '{8'h77};
    wr_seq(8, q, "R4");
    for (int i = 0; i < 3; i++) xbit(1'b1, 1'b0, "R7 partial", s);
    bus_start();
    rd_body(1, "R7 after restart");
    bus_stop();
    q = '{};
    wr_seq(8, q, "R4");
    bus_start();
    rd_body(2, "R7 partial not stored");
    bus_stop();

    // stop during the address byte
    bus_start();
    for (int i = 0; i < 3; i++) xbit(1'b0, 1'b0, "R2 partial addr", s);
    bus_stop();
    q = '{8'hC3};
    wr_seq(4, q, "R2 after stop");
    // stop inside a data byte
    for (int i = 0; i < 4; i++) xbit(1'b0, 1'b0, "R2 partial data", s);
    bus_stop();
    q = '{};
    wr_seq(4, q, "R4");
    bus_start();
    rd_body(2, "R2 data kept");
    bus_stop();

    // read from a foreign address: line never pulled
    bus_start();
    wbyte(8'h6F, 1'b0, "R3 foreign read");
    rbyte(8'hFF, 1'b0, "R3 foreign read");
    bus_stop();
    wait_clk(10);
    chk(sda_oe == 1'b0, "R5 released at end", sda_oe, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule